// File: doc/BRIEF.md
# SRAM Readback Checker

This block sits between a host request/response port and a single-port SRAM request port. With checking switched off it is a wire: host requests, grants and read responses pass straight through without added cycles. With checking on, each host access becomes a compound transaction. A read fetches the word, then reads the same address again and compares the two results. A write stores the word, waits at least one idle cycle, then reads the address back and compares the bits selected by the write mask. This lets a memory fault that corrupts a fetch or drops a store be seen.

While a compound transaction runs, the host is stalled. The read data reaches the host only after its second fetch has been compared. The verification read after a write is held back while the memory reports that a write is still pending in its holding register or that a write collision is in progress, so the check reads the array and not the holding register. Any mismatch sets a sticky error bit and fires a one-cycle fatal alert.

Top module: `sram_readback_guard`

## Requirements
- R1: With checking disabled, memory request, write enable, address, data and mask follow the host inputs in the same cycle, host grant follows memory grant, and the read response returns to the host in the cycle the memory delivers it. Each host access makes exactly one memory access.
- R2: The 4-bit enable turns checking on only at the value 4'b0110. Every other value (for example 4'b1001 or 4'b1110) behaves exactly as disabled (R1).
- R3: With checking enabled, a host read granted in cycle c makes two memory reads of the same address. The host sees rvalid, carrying the first fetch's data, in cycle c+3 when the memory answers in one cycle.
- R4: With checking enabled, a host write granted in cycle c is followed by one memory read of the written address. This read is issued no earlier than cycle c+2, leaving cycle c+1 without any memory request.
- R5: The verification read after a write is not issued while memory write-pending or write-collision is high.
- R6: While a compound transaction is in progress, host grant stays low and a host request does not reach the memory.
- R7: A read whose second fetch differs from the first in any bit is a mismatch.
- R8: A write mismatch is counted only in bits whose write mask bit is 1 (the mask is per data bit). Differences in bits with a mask bit of 0 raise no error.
- R9: A mismatch sets the error output in the cycle after the verification data arrives. The error stays set until reset. The alert output is high for exactly one cycle for each mismatch.
- R10: The busy output is high from the cycle after the original access is granted through the cycle the verification data arrives. This is three cycles for a read or unstalled write with a one-cycle memory.
- R11: After reset, error, alert, busy and host rvalid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rbEnable | input | 4 | Checking enable, multi-bit boolean; 4'b0110 is true |
| hostReq | input | 1 | Host access request |
| hostGnt | output | 1 | Host access accepted this cycle |
| hostWe | input | 1 | Host access is a write |
| hostAddr | input | AW | Host word address |
| hostWdata | input | DW | Host write data |
| hostWmask | input | DW | Host per-bit write mask |
| hostRvalid | output | 1 | Read data valid to host |
| hostRdata | output | DW | Read data to host |
| memReq | output | 1 | Memory request |
| memGnt | input | 1 | Memory request accepted |
| memWe | output | 1 | Memory write |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Memory write data |
| memWmask | output | DW | Memory per-bit write mask |
| memRvalid | input | 1 | Memory read data valid |
| memRdata | input | DW | Memory read data |
| memWrPending | input | 1 | Memory holds a write not yet in the array |
| memWrCollision | input | 1 | Memory reports a write collision |
| rbError | output | 1 | Sticky readback mismatch flag |
| rbAlert | output | 1 | One-cycle fatal alert per mismatch |
| rbBusy | output | 1 | Compound transaction in progress |

## Verification
The bench corrupts selected memory responses. A corrupted second fetch of a read must raise the error. A corruption that falls only in bits with a mask bit of 0 after a write must not; a design that compared the full word would flag it. The bench holds write-pending and write-collision high after a write and watches for early memory reads. A design that ignored them would read the holding register's stale view. During that stall the bench also raises a new host request, which a design with a leaky stall would grant. It times the read response and the write-to-verify gap against the one-cycle rule, and drives non-true enable encodings that a one-bit decode would treat as enabled.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  localparam logic [3:0] MUBI4_TRUE = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ORIG,
    ST_GAP,
    ST_RBREQ,
    ST_RBWAIT
  } rbkState_t;

  typedef struct packed {
    logic capReq;    // latch the accepted host access
    logic capFirst;  // latch data of the original read
    logic chkRd;     // verification data of a read is on memRdata
    logic chkWr;     // verification data of a write is on memRdata
    logic useSaved;  // drive memory address from the saved access
  } rbkStrobe_t;

endpackage

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
  import rbk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] rbEnable,
  input  logic       hostReq,
  input  logic       hostWe,
  input  logic       memGnt,
  input  logic       memRvalid,
  input  logic       memWrPending,
  input  logic       memWrCollision,
  output logic       hostGnt,
  output logic       memReq,
  output logic       memWe,
  output logic       passThru,
  output logic       busy,
  output rbkStrobe_t strb
);

  rbkState_t state, stateNext;
  logic      weQ;
  logic      enOn;

  assign enOn     = (rbEnable == MUBI4_TRUE);
  assign passThru = (state == ST_IDLE) && !enOn;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    strb      = '0;
    hostGnt   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        memReq  = hostReq;
        memWe   = hostWe;
        hostGnt = hostReq & memGnt;
        if (enOn && hostReq && memGnt) begin
          strb.capReq = 1'b1;
          stateNext   = hostWe ? ST_GAP : ST_ORIG;
        end
      end
      ST_ORIG: begin
        if (memRvalid) begin
          strb.capFirst = 1'b1;
          stateNext     = ST_RBREQ;
        end
      end
      ST_GAP: begin
        if (!memWrPending && !memWrCollision) stateNext = ST_RBREQ;
      end
      ST_RBREQ: begin
        memReq        = 1'b1;
        strb.useSaved = 1'b1;
        if (memGnt) stateNext = ST_RBWAIT;
      end
      ST_RBWAIT: begin
        strb.useSaved = 1'b1;
        if (memRvalid) begin
          strb.chkRd = !weQ;
          strb.chkWr = weQ;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      weQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.capReq) weQ <= hostWe;
    end
  end

  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && enOn && hostReq && memGnt && hostWe) |=> !memReq); // R4

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && (memWrPending || memWrCollision)) |=> (state == ST_GAP)); // R5

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !hostGnt); // R6

endmodule

// File: rtl/rbk_datapath.sv
module rbk_datapath
  import rbk_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  rbkStrobe_t    strb,
  input  logic          passThru,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic [DW-1:0] hostWmask,
  input  logic          memRvalid,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] memWmask,
  output logic          hostRvalid,
  output logic [DW-1:0] hostRdata,
  output logic          rbError,
  output logic          rbAlert
);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdataQ, wmaskQ, firstQ;
  logic          errQ, alertQ;
  logic          mismatch;

  assign memAddr    = strb.useSaved ? addrQ : hostAddr;
  assign memWdata   = hostWdata;
  assign memWmask   = hostWmask;
  assign hostRvalid = passThru ? memRvalid : strb.chkRd;
  assign hostRdata  = passThru ? memRdata : firstQ;

  always_comb begin
    mismatch = 1'b0;
    if (strb.chkRd) mismatch = (memRdata != firstQ);
    if (strb.chkWr) mismatch = |((memRdata ^ wdataQ) & wmaskQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wmaskQ <= '0;
      firstQ <= '0;
      errQ   <= 1'b0;
      alertQ <= 1'b0;
    end else begin
      if (strb.capReq) begin
        addrQ  <= hostAddr;
        wdataQ <= hostWdata;
        wmaskQ <= hostWmask;
      end
      if (strb.capFirst) firstQ <= memRdata;
      errQ   <= errQ | mismatch;
      alertQ <= mismatch;
    end
  end

  assign rbError = errQ;
  assign rbAlert = alertQ;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ); // R9

  AST_ALERT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    alertQ |=> !alertQ); // R9

  AST_ALERT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    alertQ |-> errQ); // R9

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!passThru && !strb.chkRd) |-> !hostRvalid); // R3

endmodule

// File: rtl/sram_readback_guard.sv
module sram_readback_guard
  import rbk_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    rbEnable,
  input  logic          hostReq,
  output logic          hostGnt,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic [DW-1:0] hostWmask,
  output logic          hostRvalid,
  output logic [DW-1:0] hostRdata,
  output logic          memReq,
  input  logic          memGnt,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] memWmask,
  input  logic          memRvalid,
  input  logic [DW-1:0] memRdata,
  input  logic          memWrPending,
  input  logic          memWrCollision,
  output logic          rbError,
  output logic          rbAlert,
  output logic          rbBusy
);

  rbkStrobe_t strb;
  logic       passThru;

  rbk_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .rbEnable       (rbEnable),
    .hostReq        (hostReq),
    .hostWe         (hostWe),
    .memGnt         (memGnt),
    .memRvalid      (memRvalid),
    .memWrPending   (memWrPending),
    .memWrCollision (memWrCollision),
    .hostGnt        (hostGnt),
    .memReq         (memReq),
    .memWe          (memWe),
    .passThru       (passThru),
    .busy           (rbBusy),
    .strb           (strb)
  );

  rbk_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .passThru   (passThru),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .hostWmask  (hostWmask),
    .memRvalid  (memRvalid),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memWmask   (memWmask),
    .hostRvalid (hostRvalid),
    .hostRdata  (hostRdata),
    .rbError    (rbError),
    .rbAlert    (rbAlert)
  );

endmodule

// File: tb/sram_readback_guard_tb.sv
module sram_readback_guard_tb;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    rbEnable = 4'b0000;
  logic          hostReq = 1'b0, hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0, hostWmask = '0;
  logic          hostGnt, hostRvalid;
  logic [DW-1:0] hostRdata;
  logic          memReq, memWe;
  logic          memGnt = 1'b1;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memWmask;
  logic          memRvalid = 1'b0;
  logic [DW-1:0] memRdata = '0;
  logic          memWrPending = 1'b0, memWrCollision = 1'b0;
  logic          rbError, rbAlert, rbBusy;

  sram_readback_guard #(.AW(AW), .DW(DW)) u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [DW-1:0] arr [16];
  int rdIdx = 0, corruptAt = -1;
  logic [DW-1:0] corruptVal = '0;
  logic [DW-1:0] expQ [$];
  int memAcc = 0, memRd = 0, lastAccCyc = 0, grantCyc = 0, rvalCyc = 0;
  int busyCnt = 0, alertCnt = 0;
  logic [AW-1:0] lastAddr = '0, prevAddr = '0;
  logic lastWe = 1'b0;
  string curReq = "R1";
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: one-cycle read latency, optional corruption of one read
  always @(posedge clk) begin
    memRvalid <= 1'b0;
    if (memReq && memGnt) begin
      if (memWe) begin
        arr[memAddr[3:0]] = (arr[memAddr[3:0]] & ~memWmask) | (memWdata & memWmask);
      end else begin
        rdIdx = rdIdx + 1;
        memRvalid <= 1'b1;
        memRdata  <= arr[memAddr[3:0]] ^ ((rdIdx == corruptAt) ? corruptVal : '0);
      end
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memGnt) begin
        memAcc++;
        if (!memWe) memRd++;
        prevAddr   = lastAddr;
        lastAddr   = memAddr;
        lastWe     = memWe;
        lastAccCyc = cyc;
      end
      if (hostReq && hostGnt) grantCyc = cyc;
      if (rbBusy) busyCnt++;
      if (rbAlert) alertCnt++;
      if (hostRvalid) begin
        rvalCyc = cyc;
        if (expQ.size() == 0) begin
          chk(0, curReq, "unexpected host rvalid", hostRdata, 0);
        end else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          chk(hostRdata == e, curReq, "host read data", hostRdata, e);
        end
      end
    end
  end

  task automatic doAccess(input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] m);
    @(posedge clk); #1;
    hostReq = 1'b1; hostWe = we; hostAddr = a; hostWdata = d; hostWmask = m;
    if (!we) expQ.push_back(arr[a[3:0]]);
    do @(negedge clk); while (!hostGnt);
    @(posedge clk); #1;
    hostReq = 1'b0; hostWe = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (rbBusy);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "R11", "watchdog expired", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, b0, r0;
    for (int i = 0; i < 16; i++) arr[i] = 32'hA500_0000 + i * 32'h0101_0101;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!rbError && !rbAlert && !rbBusy && !hostRvalid, "R11", "reset outputs",
        {rbError, rbAlert, rbBusy, hostRvalid}, 0);

    // R1 pass-through read, same-cycle forwarding
    curReq = "R1"; a0 = memAcc;
    @(posedge clk); #1;
    hostReq = 1'b1; hostAddr = 8'h03; expQ.push_back(arr[3]);
    @(negedge clk);
    chk(memReq && !memWe && memAddr == 8'h03 && hostGnt, "R1", "forwarded request",
        {memReq, memWe, hostGnt, memAddr}, {3'b101, 8'h03});
    @(posedge clk); #1 hostReq = 1'b0;
    waitDone();
    chk(memAcc - a0 == 1, "R1", "memory accesses per read", memAcc - a0, 1);
    chk(rvalCyc - grantCyc == 1, "R1", "read latency", rvalCyc - grantCyc, 1);

    // R1 pass-through write then read back
    a0 = memAcc;
    doAccess(1, 8'h05, 32'h1234_5678, 32'hFFFF_FFFF);
    waitDone();
    chk(memAcc - a0 == 1 && lastWe, "R1", "one write access", memAcc - a0, 1);
    doAccess(0, 8'h05, '0, '0);
    waitDone();

    // R2 non-true encodings behave as disabled
    curReq = "R2";
    rbEnable = 4'b1001; a0 = memAcc;
    doAccess(0, 8'h06, '0, '0);
    waitDone();
    chk(memAcc - a0 == 1, "R2", "accesses with 4'b1001", memAcc - a0, 1);
    rbEnable = 4'b1110; a0 = memAcc;
    doAccess(0, 8'h07, '0, '0);
    waitDone();
    chk(memAcc - a0 == 1 && rvalCyc - grantCyc == 1, "R2", "accesses with 4'b1110",
        memAcc - a0, 1);

    // R3 / R10 checked read
    rbEnable = 4'b0110; curReq = "R3";
    a0 = memAcc; r0 = memRd; b0 = busyCnt;
    doAccess(0, 8'h08, '0, '0);
    waitDone();
    chk(memRd - r0 == 2 && memAcc - a0 == 2, "R3", "two memory reads", memRd - r0, 2);
    chk(lastAddr == 8'h08 && prevAddr == 8'h08, "R3", "same address",
        {prevAddr, lastAddr}, 16'h0808);
    chk(rvalCyc - grantCyc == 3, "R3", "host response after check", rvalCyc - grantCyc, 3);
    chk(busyCnt - b0 == 3, "R10", "busy cycles for read", busyCnt - b0, 3);

    // R4 checked write: verify read at c+2
    curReq = "R4"; a0 = memAcc; b0 = busyCnt;
    doAccess(1, 8'h0A, 32'hCAFE_F00D, 32'hFFFF_FFFF);
    waitDone();
    chk(memAcc - a0 == 2 && !lastWe && lastAddr == 8'h0A, "R4", "verify read of address",
        lastAddr, 8'h0A);
    chk(lastAccCyc - grantCyc == 2, "R4", "write to verify gap", lastAccCyc - grantCyc, 2);
    chk(busyCnt - b0 == 3, "R10", "busy cycles for write", busyCnt - b0, 3);

    // R8 corruption in unmasked bits only: no error
    corruptAt = rdIdx + 1; corruptVal = 32'hFFFF_0000;
    doAccess(1, 8'h0B, 32'h0000_1111, 32'h0000_FFFF);
    waitDone();
    chk(!rbError && alertCnt == 0, "R8", "unmasked difference ignored", rbError, 0);

    // R5 / R6 write-pending and collision hold off the verify read
    curReq = "R5";
    @(posedge clk); #1 memWrPending = 1'b1;
    r0 = memRd;
    doAccess(1, 8'h0C, 32'h5555_AAAA, 32'hFFFF_FFFF);
    hostReq = 1'b1; hostWe = 1'b0; hostAddr = 8'h09;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!hostGnt && !memReq, "R6", "host stalled while busy", {hostGnt, memReq}, 0);
    end
    @(posedge clk); #1 hostReq = 1'b0;
    chk(memRd == r0, "R5", "no read while pending", memRd - r0, 0);
    memWrPending = 1'b0; memWrCollision = 1'b1;
    repeat (2) @(negedge clk);
    chk(memRd == r0, "R5", "no read while collision", memRd - r0, 0);
    @(posedge clk); #1 memWrCollision = 1'b0;
    waitDone();
    chk(memRd - r0 == 1 && lastAddr == 8'h0C && !rbError, "R5", "verify read after release",
        memRd - r0, 1);

    // R7 / R9 read mismatch on the second fetch
    curReq = "R7";
    corruptAt = rdIdx + 2; corruptVal = 32'h0000_0100;
    doAccess(0, 8'h0D, '0, '0);
    waitDone();
    chk(rbError, "R7", "read mismatch flagged", rbError, 1);
    chk(alertCnt == 1, "R9", "single alert pulse", alertCnt, 1);

    // R8 / R9 write mismatch in a masked bit
    curReq = "R8";
    corruptAt = rdIdx + 1; corruptVal = 32'h0000_0001;
    doAccess(1, 8'h0E, 32'h0000_00F0, 32'h0000_00FF);
    waitDone();
    chk(alertCnt == 2, "R8", "masked-bit mismatch alerts", alertCnt, 2);

    // R9 error sticks through later clean traffic
    curReq = "R9"; rbEnable = 4'b0000;
    doAccess(0, 8'h01, '0, '0);
    waitDone();
    chk(rbError && alertCnt == 2, "R9", "error sticky", {rbError, 8'(alertCnt)}, 9'h102);
    chk(expQ.size() == 0, "R3", "all responses returned", expQ.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule